// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a periodic interrupt timer with a register port. A down-counter steps once every (divider + 1) ticks of a selected tick source. When it reaches zero, it either reloads from a load register or wraps to all-ones, depending on the mode. A count step that lands on the compare value sets a sticky status flag. When the compare interrupt is enabled, that flag drives the interrupt line.

Software reaches five word registers through one shared address, a write strobe and a read strobe. A read returns its data one cycle after the strobe, marked by `rd_valid`. The register port has no back-pressure: each strobe is accepted in the cycle it is seen.

The tick sources are single-cycle enables in the `clk` domain. Two low-power request inputs pause counting unless the control register allows running in that state.

Top module: `dctmr_top`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, STATUS (address 1) reads 0, and LOAD (address 2), COMPARE (address 3) and COUNT (address 4, read-only) read all-ones. `irq` is low.
- R2: Each step lowers the count by one. A step taken at 0 loads LOAD when CTRL bit 3 (reload) is 1, and all-ones when it is 0.
- R3: A CTRL write that sets bit 0 (run) while it was clear, with bit 1 (known-start) set, loads the counter. The value loaded is LOAD when the written bit 3 is 1, and all-ones otherwise.
- R4: CTRL bits 9:8 choose which `src_tick` lane feeds the prescaler. CTRL bits 21:10 hold the divider D, and the counter steps once per D+1 ticks of the chosen lane. Ticks on any other lane have no effect.
- R5: STATUS bit 0 sets when a step produces a count equal to COMPARE, and it stays set. Writing STATUS with bit 0 = 1 clears it, unless a match occurs in the same cycle, in which case the flag stays set.
- R6: `irq` is high exactly when STATUS bit 0 and CTRL bit 2 (compare interrupt enable) are both 1.
- R7: While CTRL bit 0 is 0, the count and the prescaler hold their values. COUNT can be read at any time without affecting counting.
- R8: `wait_req` with CTRL bit 4 clear pauses counting, and so does `stop_req` with CTRL bit 5 clear. Counting resumes from the held value once the request drops. When the matching bit is set, the request has no effect.
- R9: When CTRL bit 6 (load overwrite) is 1, a LOAD write also places the written value in the counter. When bit 6 is 0, a LOAD write leaves the count unchanged.
- R10: A CTRL write with bit 7 set starts a software reset. CTRL bit 7 then reads 1 for SWR_CYCLES cycles, all writes are ignored, and afterwards every register returns to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | CNT_W | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | `rd_data` holds a read result |
| src_tick | input | 4 | Tick enable, one lane per source |
| wait_req | input | 1 | Wait-state request |
| stop_req | input | 1 | Stop-state request |
| irq | output | 1 | Compare interrupt |

## Verification
A wrong prescaler phase or a bad reload shows up as a COUNT value that is off by one or more after a known number of ticks on the chosen lane. The bench drives the lane itself, so each step can be attributed to a single tick. A lost or spurious flag event appears in STATUS and on `irq` on the same edge that the count reaches the compare value, and the bench reads it back before issuing any other tick. A soft reset that starts or finishes at the wrong time is caught through the CTRL bit 7 readback a few cycles after the write, and through the register values that follow.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;
  localparam int DIV_W  = 12;
  localparam int SRC_W  = 2;
  localparam int NSRC   = 1 << SRC_W;
  localparam int CTRL_W = DIV_W + SRC_W + 8;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_LOAD = 3'd2;
  localparam logic [2:0] A_CMP  = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SRC_W-1:0] src;
    logic             swr;
    logic             ovw;
    logic             stop_run;
    logic             wait_run;
    logic             reload;
    logic             cmp_ien;
    logic             start_known;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/dctmr_prescale.sv
module dctmr_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);
  logic [DIV_W-1:0] acc_q;

  // >= so that lowering the divider mid-period cannot strand the accumulator
  assign pulse = en && (acc_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (pulse) acc_q <= '0;
    else if (en)    acc_q <= acc_q + 1'b1;
  end
endmodule

// File: rtl/dctmr_counter.sv
module dctmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_clr,
  input  logic         load_now,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] nxt;

  always_comb begin
    if (cnt == '0) nxt = reload ? reload_val : '1;
    else           nxt = cnt - 1'b1;
  end

  assign match = step && (nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '1;
    else if (sw_clr)   cnt <= '1;
    else if (load_now) cnt <= load_val;
    else if (step)     cnt <= nxt;
  end
endmodule

// File: rtl/dctmr_flag.sv
module dctmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_clr,
  input  logic set,
  input  logic w1c,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (sw_clr) flag <= 1'b0;
    else if (set)    flag <= 1'b1;   // a match outranks a clear
    else if (w1c)    flag <= 1'b0;
  end
endmodule

// File: rtl/dctmr_top.sv
module dctmr_top
  import dctmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int SWR_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             wait_req,
  input  logic             stop_req,
  output logic             irq
);
  localparam int SWR_W = $clog2(SWR_CYCLES + 1);

  ctrl_t            ctrl_q, ctrl_wr, ctrl_view;
  logic [CNT_W-1:0] load_q, cmp_q, cnt, cnt_ld_val, rd_mux;
  logic [SWR_W-1:0] swr_cnt;
  logic             swr_busy, swr_fire, wr_ok;
  logic             ctrl_wr_en, load_wr_en, cmp_wr_en, stat_clr;
  logic             start_ld, ovw_ld, cnt_load;
  logic             paused, pre_en, step, match, flag;

  assign swr_busy   = (swr_cnt != '0);
  assign swr_fire   = (swr_cnt == SWR_W'(1));
  assign wr_ok      = wr_en && !swr_busy;
  assign ctrl_wr_en = wr_ok && (bus_addr == A_CTRL);
  assign load_wr_en = wr_ok && (bus_addr == A_LOAD);
  assign cmp_wr_en  = wr_ok && (bus_addr == A_CMP);
  assign stat_clr   = wr_ok && (bus_addr == A_STAT) && wr_data[0];
  assign ctrl_wr    = ctrl_t'(wr_data[CTRL_W-1:0]);

  assign start_ld   = ctrl_wr_en && !ctrl_wr.swr && ctrl_wr.run && !ctrl_q.run
                      && ctrl_wr.start_known;
  assign ovw_ld     = load_wr_en && ctrl_q.ovw;
  assign cnt_load   = start_ld || ovw_ld;
  assign cnt_ld_val = ovw_ld ? wr_data : (ctrl_wr.reload ? load_q : '1);

  assign paused = (wait_req && !ctrl_q.wait_run) || (stop_req && !ctrl_q.stop_run);
  assign pre_en = ctrl_q.run && !paused && !swr_busy && !cnt_load && src_tick[ctrl_q.src];

  // register file and soft-reset sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '1;
      cmp_q   <= '1;
      swr_cnt <= '0;
    end else if (swr_fire) begin
      ctrl_q  <= '0;
      load_q  <= '1;
      cmp_q   <= '1;
      swr_cnt <= '0;
    end else begin
      if (swr_busy) swr_cnt <= swr_cnt - 1'b1;
      if (ctrl_wr_en) begin
        if (ctrl_wr.swr) begin
          ctrl_q  <= '0;
          swr_cnt <= SWR_W'(SWR_CYCLES);
        end else begin
          ctrl_q     <= ctrl_wr;
          ctrl_q.swr <= 1'b0;
        end
      end
      if (load_wr_en) load_q <= wr_data;
      if (cmp_wr_en)  cmp_q  <= wr_data;
    end
  end

  dctmr_prescale #(.DIV_W(DIV_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_load || swr_fire), .en(pre_en),
    .div(ctrl_q.div), .pulse(step)
  );

  dctmr_counter #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .sw_clr(swr_fire), .load_now(cnt_load),
    .load_val(cnt_ld_val), .step(step), .reload(ctrl_q.reload),
    .reload_val(load_q), .cmp_val(cmp_q), .cnt(cnt), .match(match)
  );

  dctmr_flag i_flag (
    .clk(clk), .rst_n(rst_n), .sw_clr(swr_fire), .set(match), .w1c(stat_clr),
    .flag(flag)
  );

  assign irq = flag && ctrl_q.cmp_ien;

  always_comb begin
    ctrl_view     = ctrl_q;
    ctrl_view.swr = swr_busy;
    case (bus_addr)
      A_CTRL:  rd_mux = CNT_W'(ctrl_view);
      A_STAT:  rd_mux = CNT_W'(flag);
      A_LOAD:  rd_mux = load_q;
      A_CMP:   rd_mux = cmp_q;
      A_CNT:   rd_mux = cnt;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/dctmr_chk.sv
module dctmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic             reload,
  input logic             cnt_load,
  input logic             swr_fire,
  input logic             flag,
  input logic             stat_clr,
  input logic             run,
  input logic             paused
);
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0 && !swr_fire) |=> cnt == $past(cnt) - 1'b1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == '0 && !reload && !swr_fire) |=> (&cnt));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stat_clr && !swr_fire) |=> flag);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load && !swr_fire) |=> $stable(cnt));

  p_paused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cnt_load && !swr_fire) |=> $stable(cnt));
endmodule

bind dctmr_top dctmr_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt), .reload(ctrl_q.reload),
  .cnt_load(cnt_load), .swr_fire(swr_fire), .flag(flag), .stat_clr(stat_clr),
  .run(ctrl_q.run), .paused(paused)
);

// File: tb/test_dctmr_top.sv
`timescale 1ns/1ps
module test_dctmr_top;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic         tick1 = 1'b0;
  logic         wait_req = 1'b0, stop_req = 1'b0;
  logic         irq;
  logic [3:0]   src_tick;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  assign src_tick = {2'b00, tick1, 1'b1};

  always #2 clk = ~clk;

  dctmr_top #(.CNT_W(W), .SWR_CYCLES(4)) i_dctmr_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .src_tick(src_tick), .wait_req(wait_req), .stop_req(stop_req), .irq(irq)
  );

  function automatic logic [W-1:0] cw(input bit run, input bit sk, input bit ien,
      input bit rld, input bit wr, input bit sr, input bit ovw, input int src,
      input int div);
    return W'(div) << 10 | W'(src) << 8 | W'(ovw) << 6 | W'(sr) << 5 |
           W'(wr) << 4 | W'(rld) << 3 | W'(ien) << 2 | W'(sk) << 1 | W'(run);
  endfunction

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read results as they return
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(rd_data, 'x, "unexpected read");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input bit tk = 1'b0);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1; tick1 = tk;
    @(negedge clk);
    wr_en = 1'b0; tick1 = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick1 = 1'b1;
      @(negedge clk); tick1 = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 0, "R1 ctrl");
    rd(3'd1, 0, "R1 status");
    rd(3'd2, ONES, "R1 load");
    rd(3'd3, ONES, "R1 compare");
    rd(3'd4, ONES, "R1 count");
    chk(irq, 0, "R1 irq");
    // R9 load write without overwrite leaves count
    wr(3'd2, 10);
    rd(3'd4, ONES, "R9 no overwrite");
    wr(3'd3, 7);
    // R3 start from load, lane 1, divide by 1, reload mode
    wr(3'd0, cw(1,1,0,1,0,0,0,1,0));
    rd(3'd4, 10, "R3 start from load");
    // R4 lane 0 ticks every cycle but is not selected
    repeat (5) @(negedge clk);
    rd(3'd4, 10, "R4 unselected lane");
    // R5 match at 7
    ticks(3);
    rd(3'd4, 7, "R2 down count");
    rd(3'd1, 1, "R5 flag set");
    chk(irq, 0, "R6 irq masked");
    wr(3'd1, 1);
    rd(3'd1, 0, "R5 w1c");
    ticks(7);
    rd(3'd4, 0, "R2 reaches zero");
    ticks(1);
    rd(3'd4, 10, "R2 reload");
    // R4 divide by 3
    wr(3'd0, cw(1,1,0,1,0,0,0,1,2));
    ticks(3);
    rd(3'd4, 9, "R4 first period");
    ticks(2);
    rd(3'd4, 9, "R4 partial period");
    ticks(1);
    rd(3'd4, 8, "R4 second period");
    // R7 freeze
    wr(3'd0, cw(0,1,0,1,0,0,0,1,0));
    ticks(5);
    rd(3'd4, 8, "R7 frozen");
    // R3 free-run start at all-ones
    wr(3'd0, cw(1,1,0,0,0,0,0,1,0));
    rd(3'd4, ONES, "R3 start all-ones");
    ticks(1);
    rd(3'd4, ONES - 1, "R2 free-run step");
    // R9 overwrite
    wr(3'd0, cw(1,1,0,0,0,0,1,1,0));
    wr(3'd2, 1);
    rd(3'd4, 1, "R9 overwrite");
    ticks(2);
    rd(3'd4, ONES, "R2 wrap to all-ones");
    rd(3'd1, 0, "R5 no spurious flag");
    // R6 interrupt
    wr(3'd3, ONES - 1);
    wr(3'd0, cw(1,1,1,0,0,0,1,1,0));
    ticks(1);
    chk(irq, 1, "R6 irq raised");
    wr(3'd1, 1);
    chk(irq, 0, "R6 irq dropped");
    // R8 wait pause
    wait_req = 1'b1;
    ticks(3);
    rd(3'd4, ONES - 1, "R8 wait paused");
    wait_req = 1'b0;
    ticks(1);
    rd(3'd4, ONES - 2, "R8 wait resume");
    // R8 stop allowed
    wr(3'd0, cw(1,1,1,0,0,1,1,1,0));
    stop_req = 1'b1;
    ticks(1);
    rd(3'd4, ONES - 3, "R8 stop enabled counts");
    stop_req = 1'b0;
    // R5 match and clear in same cycle
    wr(3'd3, ONES - 4);
    wr(3'd1, 1, 1'b1);
    rd(3'd4, ONES - 4, "R5 same-cycle step");
    rd(3'd1, 1, "R5 set beats clear");
    // R10 soft reset
    wr(3'd0, W'(1) << 7);
    rd(3'd0, W'(1) << 7, "R10 busy bit");
    repeat (8) @(negedge clk);
    rd(3'd0, 0, "R10 ctrl default");
    rd(3'd1, 0, "R10 status default");
    rd(3'd2, ONES, "R10 load default");
    rd(3'd3, ONES, "R10 compare default");
    rd(3'd4, ONES, "R10 count default");
    chk(irq, 0, "R10 irq low");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(W'(exp_q.size()), 0, "reads outstanding");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule